// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Controller

This block is the digital heart of a spread-spectrum clock synthesizer. It advances a triangular sweep by one step on every clock. From that sweep it produces a signed frequency-offset word in parts per million. A downstream synthesizer adds this word to its nominal setting. A 3-bit width code sets both the sweep shape and the sweep span. In down-spread mode the offset runs from zero to minus the full span and back. In center-spread mode it swings evenly above and below zero.

Alongside the sweep, the block decodes an input-range code and an output-range code into a nominal multiplication ratio, in quarters. It flags reserved range codes. It also registers a stop request into an output-enable level.

The sweep is a five-state machine:
- `S_IDLE`: spreading is off and the offset is zero.
- `S_Q1`: first quarter, moving away from nominal.
- `S_Q2`: second quarter, turning at the peak in center mode or continuing to the floor in down mode.
- `S_Q3`: third quarter, crossing zero in center mode or returning from the floor in down mode.
- `S_Q4`: fourth quarter, closing back toward nominal.

Transitions:
- **qtr_done** moves Q1→Q2→Q3→Q4 after `HALF_STEPS/2` cycles in each quarter.
- **period_wrap** leaves the last Q4 step for Q1 when spreading is enabled, and for IDLE otherwise.
- **enable** leaves IDLE for Q1 when the enable is sampled low.
- **stay_idle** keeps IDLE when the enable is sampled high.

Width and enable are sampled only on the wrap step, or on any cycle spent in IDLE.

Top module: `ssm_profile_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, `freq_offset_ppm` is 0, `ratio_q2` is 4 (×1.0), `range_err` is 0 and `out_en` is 0; the state is IDLE.
- R2: Bit 0 of `width_sel` selects down-spread (0) or center-spread (1). Bits 2:1 give the full span S = 12500 << bits[2:1] ppm, that is 1.25%, 2.5%, 5% or 10%.
- R3: In down-spread mode, with period position p = 0 … 2·HALF_STEPS−1 counted from the wrap, the level is L = p for p ≤ HALF_STEPS and 2·HALF_STEPS−p otherwise. The offset is −floor(S·L/HALF_STEPS), which is never above 0 and reaches −S.
- R4: In center-spread mode, with Q = HALF_STEPS/2, the signed level is p for p ≤ Q, 2Q−p for p ≤ 3Q, and p−4Q otherwise. The offset has the level's sign and magnitude floor(S·|level|/HALF_STEPS), and reaches ±S/2.
- R5: When `spread_n` is sampled high at a period boundary, the offset stays 0 until it is sampled low at a boundary.
- R6: `out_en` equals the inverse of `stop` delayed by one clock.
- R7: `width_sel` and `spread_n` take effect only at a period boundary: any cycle in IDLE, or the last step of Q4. The new setting applies from the following cycle, whose offset is 0.
- R8: Range codes 01, 10 and 11 stand for minimum frequencies of 12.5, 25 and 50 MHz. One cycle after valid codes, `ratio_q2` = 4·2^(out−in): 1, 2, 4, 8 or 16 quarters.
- R9: A code of 00 on either range input sets `range_err` one cycle later and holds `ratio_q2` at its previous value. Valid codes clear `range_err` one cycle later.
- R10: Consecutive offsets never differ by more than 100000/HALF_STEPS + 1 ppm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sweep step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| width_sel | input | 3 | Spread type (bit 0) and span (bits 2:1) |
| in_range | input | 2 | Reference-range code |
| out_range | input | 2 | Output-range code |
| spread_n | input | 1 | Active-low spread enable |
| stop | input | 1 | Active-high output stop |
| freq_offset_ppm | output | OFF_W | Signed frequency offset in ppm |
| ratio_q2 | output | 5 | Multiplication ratio in quarters |
| range_err | output | 1 | Reserved range code seen |
| out_en | output | 1 | Clock output enable (low forces outputs low) |

## Verification
The hardest situation to reach is a width or enable change arriving mid-ramp, and especially one that lands exactly on the wrap step. The stimulus changes settings after run lengths that are not multiples of the period, so the changes fall at many different sweep positions. A cycle-accurate model then shows whether each new setting appeared early or late. The range inputs sweep all sixteen code pairs in turn. This exercises the case where a reserved code follows a non-unity ratio, so a failure to hold the ratio becomes visible at the ports.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    typedef enum logic [2:0] {S_IDLE, S_Q1, S_Q2, S_Q3, S_Q4} sweep_st_t;

    localparam int BASE_SPAN_PPM = 12500;
    localparam int MAX_SPAN_PPM  = BASE_SPAN_PPM << 3;

    function automatic int span_of(input logic [1:0] code);
        return BASE_SPAN_PPM << code;
    endfunction
endpackage

// File: rtl/ssm_sweep_fsm.sv
module ssm_sweep_fsm
    import ssm_pkg::*;
#(
    parameter int HALF_STEPS = 8,
    parameter int OFF_W      = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              width_sel,
    input  logic                    spread_n,
    output logic signed [OFF_W-1:0] offset_o
);
    localparam int QSTEPS  = HALF_STEPS / 2;
    localparam int QC_W    = (QSTEPS > 1) ? $clog2(QSTEPS) : 1;
    localparam int MAXSTEP = MAX_SPAN_PPM / HALF_STEPS + 1;

    sweep_st_t   st;
    logic [QC_W-1:0] qc;
    logic [2:0]  act_w;
    logic        qtr_done, wrap_step, boundary;

    assign qtr_done  = (qc == QC_W'(QSTEPS - 1));
    assign wrap_step = (st == S_Q4) && qtr_done;
    assign boundary  = (st == S_IDLE) || wrap_step;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            qc    <= '0;
            act_w <= '0;
        end else if (boundary) begin
            act_w <= width_sel;
            qc    <= '0;
            st    <= spread_n ? S_IDLE : S_Q1;
        end else if (qtr_done) begin
            qc <= '0;
            unique case (st)
                S_Q1:    st <= S_Q2;
                S_Q2:    st <= S_Q3;
                S_Q3:    st <= S_Q4;
                default: st <= S_IDLE;
            endcase
        end else begin
            qc <= qc + 1'b1;
        end
    end

    // outputs
    int  lvl, mag, span;
    logic neg;
    always_comb begin
        span = span_of(act_w[2:1]);
        lvl  = 0;
        neg  = 1'b0;
        unique case (st)
            S_IDLE: begin lvl = 0; neg = 1'b0; end
            S_Q1: begin
                lvl = int'(qc);
                neg = !act_w[0];
            end
            S_Q2: begin
                lvl = act_w[0] ? QSTEPS - int'(qc) : QSTEPS + int'(qc);
                neg = !act_w[0];
            end
            S_Q3: begin
                lvl = act_w[0] ? int'(qc) : HALF_STEPS - int'(qc);
                neg = 1'b1;
            end
            S_Q4: begin
                lvl = QSTEPS - int'(qc);
                neg = 1'b1;
            end
            default: begin lvl = 0; neg = 1'b0; end
        endcase
        mag      = (span * lvl) / HALF_STEPS;
        offset_o = OFF_W'(neg ? -mag : mag);
    end

    AST_DOWN_NONPOS: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE && !act_w[0]) |-> (offset_o <= 0)); // R3
    AST_CENTER_BOUND: assert property (@(posedge clk) disable iff (rst)
        act_w[0] |-> (int'(offset_o) <= span / 2 && int'(offset_o) >= -(span / 2))); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> (offset_o == 0)); // R5
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE && !wrap_step) |=> $stable(act_w)); // R7
    AST_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((int'(offset_o) - int'($past(offset_o))) <= MAXSTEP &&
                  (int'(offset_o) - int'($past(offset_o))) >= -MAXSTEP)); // R10
endmodule

// File: rtl/ssm_ratio_dec.sv
module ssm_ratio_dec (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] in_range,
    input  logic [1:0] out_range,
    output logic [4:0] ratio_q2,
    output logic       range_err
);
    logic       reserved;
    logic [2:0] sh;

    assign reserved = (in_range == 2'b00) || (out_range == 2'b00);
    assign sh       = 3'd2 + {1'b0, out_range} - {1'b0, in_range};

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q2  <= 5'd4;
            range_err <= 1'b0;
        end else if (reserved) begin
            range_err <= 1'b1;
        end else begin
            range_err <= 1'b0;
            ratio_q2  <= 5'd1 << sh;
        end
    end

    AST_RATIO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(ratio_q2)); // R8
    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
        reserved |=> (range_err && $stable(ratio_q2))); // R9
    AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !reserved |=> !range_err); // R9
endmodule

// File: rtl/ssm_profile_ctrl.sv
module ssm_profile_ctrl #(
    parameter int HALF_STEPS = 8,
    parameter int OFF_W      = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              width_sel,
    input  logic [1:0]              in_range,
    input  logic [1:0]              out_range,
    input  logic                    spread_n,
    input  logic                    stop,
    output logic signed [OFF_W-1:0] freq_offset_ppm,
    output logic [4:0]              ratio_q2,
    output logic                    range_err,
    output logic                    out_en
);
    ssm_sweep_fsm #(.HALF_STEPS(HALF_STEPS), .OFF_W(OFF_W)) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .width_sel (width_sel),
        .spread_n  (spread_n),
        .offset_o  (freq_offset_ppm)
    );

    ssm_ratio_dec u_ratio (
        .clk       (clk),
        .rst       (rst),
        .in_range  (in_range),
        .out_range (out_range),
        .ratio_q2  (ratio_q2),
        .range_err (range_err)
    );

    always_ff @(posedge clk) begin
        if (rst) out_en <= 1'b0;
        else     out_en <= !stop;
    end

    AST_STOP_GATE: assert property (@(posedge clk) disable iff (rst)
        stop |=> !out_en); // R6
    AST_RUN_GATE: assert property (@(posedge clk) disable iff (rst)
        !stop |=> out_en); // R6
endmodule

// File: tb/tb_ssm_profile_ctrl.sv
module tb_ssm_profile_ctrl;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;
    localparam int Q     = HALF / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] width_sel = 3'b000;
    logic [1:0] in_range = 2'b01, out_range = 2'b01;
    logic spread_n = 1'b1, stop = 1'b1;
    logic signed [17:0] freq_offset_ppm;
    logic [4:0] ratio_q2;
    logic range_err, out_en;

    int checks = 0, failures = 0;
    bit done = 0;

    ssm_profile_ctrl #(.HALF_STEPS(HALF), .OFF_W(18)) dut (
        .clk(clk), .rst(rst), .width_sel(width_sel), .in_range(in_range),
        .out_range(out_range), .spread_n(spread_n), .stop(stop),
        .freq_offset_ppm(freq_offset_ppm), .ratio_q2(ratio_q2),
        .range_err(range_err), .out_en(out_en));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference
    bit m_idle = 1; int m_pos = 0; int m_w = 0;
    int m_ratio = 4; int m_err = 0; int m_gate = 0;
    int min_dn10 = 0, max_ce10 = 0, min_ce10 = 0;
    bit mid_seen = 0;

    function automatic int exp_offset();
        int span, lvl, mag;
        if (m_idle) return 0;
        span = 12500 * (1 << (m_w >> 1));
        if ((m_w & 1) == 0) begin
            lvl = (m_pos <= HALF) ? m_pos : 2*HALF - m_pos;
            return -((span * lvl) / HALF);
        end
        if (m_pos <= Q)          lvl = m_pos;
        else if (m_pos <= 3*Q)   lvl = 2*Q - m_pos;
        else                     lvl = m_pos - 4*Q;
        mag = (span * (lvl < 0 ? -lvl : lvl)) / HALF;
        return (lvl < 0) ? -mag : mag;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_idle = 1; m_pos = 0; m_w = 0; m_ratio = 4; m_err = 0; m_gate = 0;
        end else begin
            if (m_idle || m_pos == 2*HALF - 1) begin
                m_w = int'(width_sel);
                m_pos = 0;
                m_idle = spread_n;
            end else m_pos++;
            if (in_range == 0 || out_range == 0) m_err = 1;
            else begin
                m_err = 0;
                m_ratio = (4 << out_range) >> in_range;
            end
            m_gate = !stop;
        end
        #2;
        if (rst) begin
            chk("R1 offset", int'(freq_offset_ppm), 0);
            chk("R1 ratio", int'(ratio_q2), 4);
            chk("R1 err", int'(range_err), 0);
            chk("R1 out_en", int'(out_en), 0);
        end else begin
            chk(m_idle ? "R5 offset idle" : ((m_w & 1) ? "R4 center offset" : "R3 down offset"),
                int'(freq_offset_ppm), exp_offset());
            chk("R8 ratio", int'(ratio_q2), m_ratio);
            chk("R9 range_err", int'(range_err), m_err);
            chk("R6 out_en", int'(out_en), m_gate);
            if (!m_idle && m_w == 6 && int'(freq_offset_ppm) < min_dn10) min_dn10 = int'(freq_offset_ppm);
            if (!m_idle && m_w == 7 && int'(freq_offset_ppm) > max_ce10) max_ce10 = int'(freq_offset_ppm);
            if (!m_idle && m_w == 7 && int'(freq_offset_ppm) < min_ce10) min_ce10 = int'(freq_offset_ppm);
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(3);
        rst = 1'b0; stop = 1'b0;
        spread_n = 1'b0; width_sel = 3'b000;          // R2 down 1.25%
        run(37);
        width_sel = 3'b001; run(41);                   // R4 center 0.625%, mid-period change R7
        width_sel = 3'b111; run(45);                   // R4 center 10%
        width_sel = 3'b110; run(39);                   // R3 down 10%
        stop = 1'b1; run(3); stop = 1'b0;              // R6
        width_sel = 3'b100; run(35);
        width_sel = 3'b011; run(33);
        width_sel = 3'b010; run(34);
        width_sel = 3'b101; run(23);
        spread_n = 1'b1; run(30);                      // R5 disable mid-period
        spread_n = 1'b0; width_sel = 3'b001; run(21);
        // R7 change exactly two steps before the wrap is ignored until wrap
        begin
            int guard = 0;
            while (!(m_pos == 2*HALF - 3 && !m_idle) && guard < 100) begin @(negedge clk); guard++; end
            width_sel = 3'b111;
            @(negedge clk);
            chk("R7 held mid-period", int'(freq_offset_ppm), exp_offset());
            mid_seen = (m_w == 1);
            chk("R7 old width kept", int'(mid_seen), 1);
            run(20);
        end
        // R8/R9 all range pairs, reserved after non-unity ratio
        for (int o = 0; o < 4; o++) begin
            for (int i = 0; i < 4; i++) begin
                in_range = 2'(i); out_range = 2'(o);
                run(2);
            end
        end
        in_range = 2'b01; out_range = 2'b11; run(2);
        in_range = 2'b00; run(3);
        chk("R9 ratio held", int'(ratio_q2), 16);
        chk("R9 err set", int'(range_err), 1);
        in_range = 2'b01; run(2);
        chk("R3 down 10% floor", min_dn10, -100000);
        chk("R4 center 10% peak", max_ce10, 50000);
        chk("R4 center 10% trough", min_ce10, -50000);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule